// File: doc/BRIEF.md
# ADC Sample Timing Sequencer

This block produces the sample timing for a converter front end that takes samples one after another. It runs on the converter clock. A start-up wait of a selectable power-of-two length comes before the first sample. A programmable gap of zero to fifteen cycles comes before every sample. During the gap the sampling capacitor is held open. As an option, the gap grows by one cycle after each sample and wraps from fifteen back to zero. This moves the sampling instant from sample to sample, so periodic interference does not build a fixed tone in the spectrum.

Software writes an 8-bit control word through a write strobe. Three events start the start-up wait while the block is enabled: enable going high, a switch to an internal reference, and a wake from deep sleep. After the start-up wait has run, each start/continue request produces one more gap followed by one sample strobe. The gap value currently in use is shown on an output.

Top module: `adc_seq_timer`

## Requirements
- R1: After a synchronous reset the control word is 0, `dly_o` is 0, and `samp_o`, `cap_open_o` and `busy_o` are low.
- R2: A write (`ctrl_wr_i` high) stores `ctrl_i`. Its fields are: bits 7:5 start-up code, bit 4 auto-step enable, bits 3:0 gap length. `dly_o` shows the written gap field from the cycle after the write.
- R3: While `en_i` is high, any of these starts the start-up wait: a low-to-high change of `en_i`, a pulse on `ref_chg_i`, or a pulse on `wake_i`. `busy_o` is high in the following cycle.
- R4: Start-up codes 0, 1, 2, 3, 4 and 5 give waits of 0, 16, 32, 64, 128 and 256 cycles. If a trigger is sampled at edge k, `samp_o` is high after edge k+N+D, where N is the start-up wait and D is the gap.
- R5: Start-up codes 6 and 7 are reserved. They give a start-up wait of 0 cycles.
- R6: A request (`req_i`) sampled at edge k while the block is enabled and idle makes `samp_o` high after edge k+D. With a gap of 0 the strobe comes in the next cycle.
- R7: `cap_open_o` is high for exactly D cycles before each strobe, and low at all other times.
- R8: `samp_o` is a one-cycle pulse. `busy_o` is high from the cycle after a trigger or request up to and including the strobe cycle, and low in the cycle after the strobe.
- R9: With bit 4 set, `dly_o` increases by one in the cycle after each strobe. With bit 4 clear, `dly_o` keeps its value. A write in the strobe cycle overrides the step.
- R10: With bit 4 set and `dly_o` equal to 15, the step after a strobe gives 0.
- R11: A control write made during a running count does not change that count. A new start-up code applies from the next trigger.
- R12: With `en_i` low, `busy_o` is low in the next cycle and requests are ignored. A request made while busy is ignored and not held for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable |
| ref_chg_i | input | 1 | Pulse: reference switched to internal |
| wake_i | input | 1 | Pulse: wake from deep sleep for a measurement |
| req_i | input | 1 | Start/continue request for the next sample |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_i | input | 8 | Control word data |
| samp_o | output | 1 | One-cycle sample strobe |
| cap_open_o | output | 1 | Sampling capacitor held open (gap running) |
| busy_o | output | 1 | Sequence in progress |
| dly_o | output | 4 | Gap value currently in use |

## Verification
The strobe is due N+D edges after the edge that samples a trigger, and D edges after the edge that samples a request. `busy_o` is high for N+D+1 cycles, `cap_open_o` is high for D cycles, and `dly_o` changes in the cycle after a write or a strobe. The bench drives inputs on the falling edge. It counts falling-edge samples from the trigger up to the strobe and compares that count with the latency formula. It also compares every output with a behavioural model on every falling edge. Because both comparisons happen half a cycle after each register updates, no check depends on the order of processes at a clock edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int GAP_W          = 4;
    localparam int CODE_W         = 3;
    localparam int INIT_BASE_LOG2 = 4;
    localparam int INIT_NUM_CODES = 6;
    localparam int WORD_W         = CODE_W + 1 + GAP_W;
    localparam int INIT_MAX       = 1 << (INIT_BASE_LOG2 + INIT_NUM_CODES - 2);
    localparam int CNT_W          = $clog2(INIT_MAX + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [CODE_W-1:0] init_code;
        logic              auto_var;
        logic [GAP_W-1:0]  gap;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_GAP,
        ST_STRB
    } phase_e;

    // Code 0 and the reserved codes give no wait; code c gives 2^(base+c-1) cycles
    function automatic cnt_t init_len(logic [CODE_W-1:0] code);
        cnt_t r;
        r = '0;
        if (code != '0 && int'(code) < INIT_NUM_CODES)
            r = cnt_t'(1) << (INIT_BASE_LOG2 + int'(code) - 1);
        return r;
    endfunction

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic ref_chg_i,
    input  logic wake_i,
    output logic trig_o
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_i;
    end

    assign trig_o = en_i & (~en_q | ref_chg_i | wake_i);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              bump_i,
    output ctrl_t             ctrl_o,
    output logic [GAP_W-1:0]  dly_o
);
    ctrl_t            ctrl_q;
    logic [GAP_W-1:0] dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            dly_q  <= '0;
        end else if (wr_i) begin
            ctrl_q <= ctrl_t'(wdata_i);
            dly_q  <= wdata_i[GAP_W-1:0];
        end else if (bump_i && ctrl_q.auto_var) begin
            dly_q  <= dly_q + GAP_W'(1);
        end
    end

    assign ctrl_o = ctrl_q;
    assign dly_o  = dly_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             trig_i,
    input  logic             req_i,
    input  cnt_t             init_len_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             strobe_o,
    output logic             cap_open_o,
    output logic             busy_o
);
    phase_e phase_q, phase_d;
    cnt_t   cnt_q, cnt_d;

    phase_e gap_phase;
    cnt_t   gap_cnt;

    always_comb begin
        if (gap_i == '0) begin
            gap_phase = ST_STRB;
            gap_cnt   = '0;
        end else begin
            gap_phase = ST_GAP;
            gap_cnt   = cnt_t'(gap_i);
        end
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (!en_i) begin
            phase_d = ST_IDLE;
            cnt_d   = '0;
        end else if (trig_i) begin
            if (init_len_i != '0) begin
                phase_d = ST_INIT;
                cnt_d   = init_len_i;
            end else begin
                phase_d = gap_phase;
                cnt_d   = gap_cnt;
            end
        end else begin
            unique case (phase_q)
                ST_IDLE: begin
                    if (req_i) begin
                        phase_d = gap_phase;
                        cnt_d   = gap_cnt;
                    end
                end
                ST_INIT: begin
                    if (cnt_q == cnt_t'(1)) begin
                        phase_d = gap_phase;
                        cnt_d   = gap_cnt;
                    end else begin
                        cnt_d = cnt_q - cnt_t'(1);
                    end
                end
                ST_GAP: begin
                    if (cnt_q == cnt_t'(1)) begin
                        phase_d = ST_STRB;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - cnt_t'(1);
                    end
                end
                ST_STRB: begin
                    phase_d = ST_IDLE;
                end
                default: phase_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign strobe_o   = (phase_q == ST_STRB);
    assign cap_open_o = (phase_q == ST_GAP);
    assign busy_o     = (phase_q != ST_IDLE);
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              ref_chg_i,
    input  logic              wake_i,
    input  logic              req_i,
    input  logic              ctrl_wr_i,
    input  logic [WORD_W-1:0] ctrl_i,
    output logic              samp_o,
    output logic              cap_open_o,
    output logic              busy_o,
    output logic [GAP_W-1:0]  dly_o
);
    ctrl_t ctrl_q;
    logic  trig;
    logic  strobe;
    cnt_t  init_cycles;

    adc_seq_trig u_trig (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .ref_chg_i (ref_chg_i),
        .wake_i    (wake_i),
        .trig_o    (trig)
    );

    adc_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (ctrl_wr_i),
        .wdata_i (ctrl_i),
        .bump_i  (strobe),
        .ctrl_o  (ctrl_q),
        .dly_o   (dly_o)
    );

    assign init_cycles = init_len(ctrl_q.init_code);

    adc_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .trig_i     (trig),
        .req_i      (req_i),
        .init_len_i (init_cycles),
        .gap_i      (dly_o),
        .strobe_o   (strobe),
        .cap_open_o (cap_open_o),
        .busy_o     (busy_o)
    );

    assign samp_o = strobe;
endmodule

// File: rtl/adc_seq_timer_chk.sv
module adc_seq_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_i,
    input logic       ctrl_wr_i,
    input logic       auto_var,
    input logic       samp_o,
    input logic       cap_open_o,
    input logic       busy_o,
    input logic [3:0] dly_o
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        samp_o |=> !samp_o);

    a_r8_strobe_busy: assert property (@(posedge clk) disable iff (rst)
        samp_o |-> busy_o);

    a_r7_cap_in_seq: assert property (@(posedge clk) disable iff (rst)
        cap_open_o |-> (busy_o && !samp_o));

    a_r12_disable_idle: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !busy_o);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!samp_o && !ctrl_wr_i) |=> $stable(dly_o));

    a_r10_step_wrap: assert property (@(posedge clk) disable iff (rst)
        (samp_o && auto_var && !ctrl_wr_i) |=> (dly_o == $past(dly_o) + 4'd1));
endmodule

bind adc_seq_timer adc_seq_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .ctrl_wr_i  (ctrl_wr_i),
    .auto_var   (ctrl_q.auto_var),
    .samp_o     (samp_o),
    .cap_open_o (cap_open_o),
    .busy_o     (busy_o),
    .dly_o      (dly_o)
);

// File: tb/adc_seq_timer_test.sv
`timescale 1ns/1ps
module adc_seq_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0, ref_chg_i = 1'b0, wake_i = 1'b0, req_i = 1'b0;
    logic       ctrl_wr_i = 1'b0;
    logic [7:0] ctrl_i = 8'h00;
    logic       samp_o, cap_open_o, busy_o;
    logic [3:0] dly_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    adc_seq_timer uut (
        .clk(clk), .rst(rst), .en_i(en_i), .ref_chg_i(ref_chg_i),
        .wake_i(wake_i), .req_i(req_i), .ctrl_wr_i(ctrl_wr_i), .ctrl_i(ctrl_i),
        .samp_o(samp_o), .cap_open_o(cap_open_o), .busy_o(busy_o), .dly_o(dly_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_code = 0, m_auto = 0, m_gap = 0, m_dly = 0;
    int m_en_d = 0;
    int m_phase = 0;   // 0 idle, 1 start-up wait, 2 gap, 3 strobe
    int m_rem = 0;

    function automatic int wait_of(int code);
        if (code < 1 || code > 5) return 0;
        return 16 << (code - 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_code = 0; m_auto = 0; m_gap = 0; m_dly = 0;
            m_en_d = 0; m_phase = 0; m_rem = 0;
        end else begin
            int old_dly, old_code, old_auto, old_phase;
            bit trig;
            old_dly = m_dly; old_code = m_code; old_auto = m_auto; old_phase = m_phase;
            trig = en_i && (m_en_d == 0 || ref_chg_i || wake_i);
            if (!en_i) begin
                m_phase = 0;
            end else if (trig) begin
                if (wait_of(old_code) > 0) begin
                    m_phase = 1; m_rem = wait_of(old_code);
                end else if (old_dly > 0) begin
                    m_phase = 2; m_rem = old_dly;
                end else m_phase = 3;
            end else begin
                case (old_phase)
                    0: if (req_i) begin
                           if (old_dly > 0) begin m_phase = 2; m_rem = old_dly; end
                           else m_phase = 3;
                       end
                    1: if (m_rem == 1) begin
                           if (old_dly > 0) begin m_phase = 2; m_rem = old_dly; end
                           else m_phase = 3;
                       end else m_rem--;
                    2: if (m_rem == 1) m_phase = 3; else m_rem--;
                    default: m_phase = 0;
                endcase
            end
            if (ctrl_wr_i) begin
                m_code = ctrl_i[7:5]; m_auto = ctrl_i[4]; m_gap = ctrl_i[3:0];
                m_dly = ctrl_i[3:0];
            end else if (old_phase == 3 && old_auto != 0) begin
                m_dly = (old_dly + 1) % 16;
            end
            m_en_d = en_i;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // every-cycle comparison against the model, half a cycle after the edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R4/R6", "samp_o", int'(samp_o), int'(m_phase == 3));
            check("R7", "cap_open_o", int'(cap_open_o), int'(m_phase == 2));
            check("R8", "busy_o", int'(busy_o), int'(m_phase != 0));
            check("R9", "dly_o", int'(dly_o), m_dly);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic write_ctrl(input logic [2:0] code, input logic auto_v, input logic [3:0] gap);
        ctrl_i = {code, auto_v, gap};
        ctrl_wr_i = 1'b1;
        @(negedge clk);
        ctrl_wr_i = 1'b0;
    endtask

    // Called right after a trigger/request has been driven on a falling edge.
    task automatic measure(input string req, input int exp_lat, input int exp_cap,
                           input int wr_at, input logic [7:0] wr_word);
        int lat = 0, capc = 0, busyc = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            req_i = 1'b0; ref_chg_i = 1'b0; wake_i = 1'b0; ctrl_wr_i = 1'b0;
            if (cap_open_o) capc++;
            if (busy_o) busyc++;
            if (samp_o) break;
            if (i == wr_at) begin ctrl_i = wr_word; ctrl_wr_i = 1'b1; end
            lat++;
        end
        check(req, "strobe latency", lat, exp_lat);
        check("R7", "cap open cycles", capc, exp_cap);
        check("R8", "busy cycles", busyc, exp_lat + 1);
        @(negedge clk);
        check("R8", "busy after strobe", int'(busy_o), 0);
    endtask

    task automatic reenable();
        en_i = 1'b0;
        @(negedge clk);
        en_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "samp_o", int'(samp_o), 0);
        check("R1", "busy_o", int'(busy_o), 0);
        check("R1", "cap_open_o", int'(cap_open_o), 0);
        check("R1", "dly_o", int'(dly_o), 0);

        // R2: write shows gap field next cycle
        write_ctrl(3'd1, 1'b0, 4'd3);
        check("R2", "dly_o after write", int'(dly_o), 3);

        // R3/R4/R5: enable rising edge, every start-up code with gap 2
        for (int c = 0; c < 8; c++) begin
            write_ctrl(3'(c), 1'b0, 4'd2);
            reenable();
            measure((c > 5) ? "R5" : "R4", wait_of(c) + 2, 2, -1, 8'h00);
        end

        // R3: reference change and wake triggers while enabled
        write_ctrl(3'd1, 1'b0, 4'd1);
        ref_chg_i = 1'b1;
        measure("R3", 17, 1, -1, 8'h00);
        wake_i = 1'b1;
        measure("R3", 17, 1, -1, 8'h00);

        // R6: requests with gap 0 and gap 5
        write_ctrl(3'd0, 1'b0, 4'd0);
        req_i = 1'b1;
        measure("R6", 0, 0, -1, 8'h00);
        write_ctrl(3'd0, 1'b0, 4'd5);
        req_i = 1'b1;
        measure("R6", 5, 5, -1, 8'h00);
        check("R9", "dly_o held without auto", int'(dly_o), 5);

        // R9/R10: auto-step from 14 through wrap
        write_ctrl(3'd0, 1'b1, 4'd14);
        req_i = 1'b1;
        measure("R9", 14, 14, -1, 8'h00);
        check("R9", "dly_o stepped", int'(dly_o), 15);
        req_i = 1'b1;
        measure("R10", 15, 15, -1, 8'h00);
        check("R10", "dly_o wrapped", int'(dly_o), 0);
        req_i = 1'b1;
        measure("R10", 0, 0, -1, 8'h00);
        check("R10", "dly_o after wrap", int'(dly_o), 1);

        // R11: rewrite start-up code mid-count (same gap)
        write_ctrl(3'd3, 1'b0, 4'd2);
        reenable();
        measure("R11", 66, 2, 10, {3'd0, 1'b0, 4'd2});
        reenable();
        measure("R11", 2, 2, -1, 8'h00);

        // R12: disable mid-count
        write_ctrl(3'd2, 1'b0, 4'd1);
        reenable();
        repeat (5) @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        check("R12", "busy after disable", int'(busy_o), 0);
        req_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R12", "request while disabled", int'(busy_o), 0);
        req_i = 1'b0;
        // R12: request while busy is dropped
        write_ctrl(3'd1, 1'b0, 4'd0);
        en_i = 1'b1;
        @(negedge clk);
        req_i = 1'b1;
        measure("R12", 15, 0, -1, 8'h00);
        repeat (3) @(negedge clk);
        check("R12", "request while busy dropped", int'(busy_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule